// File: doc/BRIEF.md
# Series Maximum, Sum and Sort Engine

This block takes a short series of unsigned 8-bit values, one value per clock, and reports three results about the series on one 11-bit result port. The first result is the largest element. The second is the total of all elements. The third is every element in ascending order, one per cycle. The length of the series, from two to six elements, arrives on a small input together with the first element. The block then counts the elements in by itself.

The results follow one another with no idle cycles. The largest element appears on the cycle right after the last element is taken in. The total follows on the next cycle, and then the sorted elements. On the cycle after the last sorted element, the block takes the first element of the next series. No reset is needed between series. Values are sorted as they arrive, by insertion into an ordered register file. The maximum and the total are accumulated while the series is loading, so no extra cycles are spent after the series is complete.

Top module: `series_stat_engine`

## Requirements
- R1: An asserted reset (active high, asynchronous) immediately forces `result` to zero. After reset is released, the block takes the first element of a new series on the next rising edge.
- R2: In the loading phase, the block captures `data_in` on each rising edge, for exactly as many edges as the series length. The length lies between 2 and 6.
- R3: The series length on `series_len` is sampled only on the first loading cycle of a series. Values on that input during the remaining loading cycles have no effect.
- R4: On the cycle directly after the last element is captured, `result` shows the maximum of the series, zero-extended to 11 bits.
- R5: On the cycle after the maximum, `result` shows the sum of the series as an 11-bit unsigned value. The sum is exact up to six elements of 255 each (1530).
- R6: Starting on the cycle after the sum, `result` shows the series elements in non-decreasing order, one per cycle, for exactly series-length cycles. Equal elements each appear, so duplicates are kept.
- R7: The cycle after the last sorted element is the first loading cycle of the next series. No idle cycle and no reset come between the two.
- R8: While elements are being loaded, `result` is zero.
- R9: During the maximum, sum and sorted output cycles, `data_in` and `series_len` are ignored. Values on them during these cycles do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on its rising edge. |
| rst | input | 1 | Asynchronous reset, active high. |
| data_in | input | 8 | Series element, unsigned. |
| series_len | input | 3 | Number of elements in the series (2 to 6). Valid on the first loading cycle. |
| result | output | 11 | Zero, maximum, sum or the next sorted element, depending on the phase. |

## Verification
The bench builds the block with its default parameters: 8-bit elements and at most six elements per series. With these values the 11-bit sum can reach its largest case of six elements of 255, and the shortest and longest series both occur. Random series between the directed ones bring in equal elements in random positions and random lengths. Changing values on the length and data inputs outside their sampling cycles show whether those inputs are wrongly taken in. Resets are asserted at random points in the output phases, which checks that the block restarts cleanly from any phase.

// File: rtl/sse_pkg.sv
package sse_pkg;

  localparam int DEF_DATA_W  = 8;
  localparam int DEF_MAX_LEN = 6;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_MAX  = 2'd1,
    PH_SUM  = 2'd2,
    PH_SORT = 2'd3
  } phase_e;

endpackage

// File: rtl/sse_ctrl.sv
module sse_ctrl
  import sse_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] series_len,
  output phase_e           phase,
  output logic [LEN_W-1:0] idx,
  output logic             capture,
  output logic             first,
  output logic             last_in,
  output logic             last_out
);

  phase_e           phase_q;
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_eff;
  logic [LEN_W-1:0] idx_end;

  assign capture  = (phase_q == PH_LOAD);
  assign first    = capture && (idx_q == '0);
  // length is taken live on the first loading cycle, held afterwards
  assign len_eff  = first ? series_len : len_q;
  assign idx_end  = len_eff - LEN_W'(1);
  assign last_in  = capture && (idx_q == idx_end);
  assign last_out = (phase_q == PH_SORT) && (idx_q == idx_end);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase_q <= PH_LOAD;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      if (first) len_q <= series_len;
      unique case (phase_q)
        PH_LOAD: begin
          if (last_in) begin
            phase_q <= PH_MAX;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + LEN_W'(1);
          end
        end
        PH_MAX:  phase_q <= PH_SUM;
        PH_SUM: begin
          phase_q <= PH_SORT;
          idx_q   <= '0;
        end
        PH_SORT: begin
          if (last_out) begin
            phase_q <= PH_LOAD;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + LEN_W'(1);
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  assign phase = phase_q;
  assign idx   = idx_q;

endmodule

// File: rtl/sse_accum.sv
module sse_accum #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              first,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] max_q,
  output logic [SUM_W-1:0]  sum_q
);

  function automatic logic [DATA_W-1:0] larger(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [SUM_W-1:0] widen_add(input logic [SUM_W-1:0]  acc,
                                                 input logic [DATA_W-1:0] d);
    return acc + SUM_W'(d);
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      max_q <= '0;
      sum_q <= '0;
    end else if (capture) begin
      max_q <= first ? data_in : larger(max_q, data_in);
      sum_q <= widen_add(first ? '0 : sum_q, data_in);
    end
  end

endmodule

// File: rtl/sse_sorter.sv
module sse_sorter #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  logic [IDX_W-1:0]  ins_cnt,
  input  logic [DATA_W-1:0] ins_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DATA_W-1:0] slot_d [DEPTH];
  logic [DEPTH-1:0]  stay;

  // Ordered insertion: a slot holding a value not above the newcomer
  // stays; the first slot past them takes the newcomer; the rest shift up.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign stay[i] = (IDX_W'(i) < ins_cnt) && (slot_q[i] <= ins_data);
    if (i == 0) begin : g_head
      assign slot_d[i] = stay[i] ? slot_q[i] : ins_data;
    end else begin : g_body
      assign slot_d[i] = stay[i]   ? slot_q[i] :
                         stay[i-1] ? ins_data  : slot_q[i-1];
    end
    always_ff @(posedge clk or posedge rst) begin
      if (rst)         slot_q[i] <= '0;
      else if (ins_en) slot_q[i] <= slot_d[i];
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/series_stat_engine.sv
module series_stat_engine
  import sse_pkg::*;
#(
  parameter  int DATA_W  = DEF_DATA_W,
  parameter  int MAX_LEN = DEF_MAX_LEN,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int RES_W   = DATA_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LEN_W-1:0]  series_len,
  output logic [RES_W-1:0]  result
);

  phase_e            phase;
  logic [LEN_W-1:0]  idx;
  logic              capture;
  logic              first;
  logic              last_in;
  logic              last_out;
  logic [DATA_W-1:0] max_q;
  logic [RES_W-1:0]  sum_q;
  logic [DATA_W-1:0] sorted_val;

  // named events for the checker
  logic ev_capture, ev_last_in, ev_show_max, ev_show_sum, ev_show_sort, ev_last_out;
  assign ev_capture   = capture;
  assign ev_last_in   = last_in;
  assign ev_show_max  = (phase == PH_MAX);
  assign ev_show_sum  = (phase == PH_SUM);
  assign ev_show_sort = (phase == PH_SORT);
  assign ev_last_out  = last_out;

  sse_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .series_len(series_len),
    .phase     (phase),
    .idx       (idx),
    .capture   (capture),
    .first     (first),
    .last_in   (last_in),
    .last_out  (last_out)
  );

  sse_accum #(.DATA_W(DATA_W), .SUM_W(RES_W)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .capture(capture),
    .first  (first),
    .data_in(data_in),
    .max_q  (max_q),
    .sum_q  (sum_q)
  );

  sse_sorter #(.DATA_W(DATA_W), .DEPTH(MAX_LEN), .IDX_W(LEN_W)) u_sorter (
    .clk     (clk),
    .rst     (rst),
    .ins_en  (capture),
    .ins_cnt (idx),
    .ins_data(data_in),
    .rd_idx  (idx),
    .rd_data (sorted_val)
  );

  always_comb begin
    unique case (phase)
      PH_MAX:  result = RES_W'(max_q);
      PH_SUM:  result = sum_q;
      PH_SORT: result = RES_W'(sorted_val);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/sse_checker.sv
module sse_checker #(
  parameter int RES_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [RES_W-1:0] result,
  input logic             ev_capture,
  input logic             ev_last_in,
  input logic             ev_show_max,
  input logic             ev_show_sum,
  input logic             ev_show_sort,
  input logic             ev_last_out
);

  p_zero_while_loading_r8: assert property (@(posedge clk) disable iff (rst)
    ev_capture |-> (result == '0));

  p_max_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    ev_last_in |=> ev_show_max);

  p_sum_after_max_r5: assert property (@(posedge clk) disable iff (rst)
    ev_show_max |=> ev_show_sum);

  p_sum_not_below_max_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_show_sum && $past(ev_show_max)) |-> (result >= $past(result)));

  p_sort_after_sum_r6: assert property (@(posedge clk) disable iff (rst)
    ev_show_sum |=> ev_show_sort);

  p_sort_nondecreasing_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_show_sort && $past(ev_show_sort)) |-> (result >= $past(result)));

  p_reload_after_sort_r7: assert property (@(posedge clk) disable iff (rst)
    ev_last_out |=> ev_capture);

  p_one_phase_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({ev_capture, ev_show_max, ev_show_sum, ev_show_sort}) == 1);

endmodule

bind series_stat_engine sse_checker #(.RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .result      (result),
  .ev_capture  (ev_capture),
  .ev_last_in  (ev_last_in),
  .ev_show_max (ev_show_max),
  .ev_show_sum (ev_show_sum),
  .ev_show_sort(ev_show_sort),
  .ev_last_out (ev_last_out)
);

// File: tb/series_stat_engine_test.sv
module series_stat_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_in = '0;
  logic [2:0]  series_len = 3'd2;
  logic [10:0] result;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  series_stat_engine uut (
    .clk       (clk),
    .rst       (rst),
    .data_in   (data_in),
    .series_len(series_len),
    .result    (result)
  );

  task automatic check(input int actual, input int expected, input string tag);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Reference: per cycle, expected result for one series.
  // abort_at >= 0 asserts reset at that output cycle instead of checking it.
  task automatic run_series(input int vals[$], input bit release_rst, input int abort_at);
    int n = vals.size();
    int mx = 0;
    int sm = 0;
    int srt[$];
    int expq[$];
    foreach (vals[i]) begin
      if (vals[i] > mx) mx = vals[i];
      sm += vals[i];
    end
    srt = vals;
    srt.sort();
    expq.push_back(mx);
    expq.push_back(sm);
    foreach (srt[i]) expq.push_back(srt[i]);

    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(int'(result), 0, (i == 0) ? "R1 R7 R8 zero before load" : "R2 R8 zero while loading");
      if (release_rst && i == 0) rst = 1'b0;
      data_in = 8'(vals[i]);
      // R3: only the first loading cycle carries the real length
      series_len = (i == 0) ? 3'(n) : 3'($urandom_range(7, 0));
    end
    for (int k = 0; k < expq.size(); k++) begin
      @(negedge clk);
      if (k == abort_at) begin
        rst = 1'b1;
        #1;
        check(int'(result), 0, "R1 reset forces zero");
        return;
      end
      check(int'(result), expq[k],
            (k == 0) ? "R4 R9 maximum" : (k == 1) ? "R5 R9 sum" : "R6 R9 sorted element");
      // R9: garbage on the inputs during output cycles
      data_in    = 8'($urandom);
      series_len = 3'($urandom);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int v[$];
    repeat (3) begin
      @(negedge clk);
      check(int'(result), 0, "R1 zero in reset");
    end
    // R5: largest sum, longest series
    v = '{255, 255, 255, 255, 255, 255};
    run_series(v, 1'b1, -1);
    // shortest series, all zero
    v = '{0, 0};
    run_series(v, 1'b0, -1);
    // R6: descending with duplicates
    v = '{200, 150, 150, 90, 7, 7};
    run_series(v, 1'b0, -1);
    // ascending, mid length
    v = '{1, 2, 3, 4};
    run_series(v, 1'b0, -1);
    v = '{9, 200, 9};
    run_series(v, 1'b0, -1);
    v = '{128, 3, 255, 0, 77};
    run_series(v, 1'b0, -1);
    // reset in the middle of output, then clean restart (R1)
    v = '{40, 30, 20, 10, 5};
    run_series(v, 1'b0, 4);
    v = '{12, 250};
    run_series(v, 1'b1, -1);
    for (int s = 0; s < 160; s++) begin
      int n = $urandom_range(6, 2);
      bit abort = (s % 23 == 22);
      v = {};
      for (int j = 0; j < n; j++) v.push_back((s % 3 == 0) ? $urandom_range(3, 0) : $urandom_range(255, 0));
      run_series(v, 1'b0, abort ? $urandom_range(n + 1, 0) : -1);
      if (abort) begin
        v = '{5, 5, 1};
        run_series(v, 1'b1, -1);
      end
    end
    @(negedge clk);
    check(int'(result), 0, "R7 R8 next series loading");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule